// File: doc/BRIEF.md
# Two-wire serial host register front-end

This block is the software-facing register file of a two-wire serial host controller. It sits on a simple 32-bit register bus. It holds the settings for a transaction: the target register byte, the write data, the command, the runtime and hardware device addresses, the device-mode bytes and the bus clock settings. When software asks for a transfer, the block hands the settings to a separate serial engine through a start/done/error handshake. The wire protocol runs in that engine, not here.

Software starts a transfer with a control bit, which reads back as set until the engine reports the end. Software can also launch a device-mode initialisation sequence with a self-clearing bit in its own register. Outcomes are recorded in a write-one-to-clear status word: transfer over, transfer error (with the failing byte index and a missing-acknowledge flag), and load-busy. Load-busy flags an attempt to change the address, data or command register while a transfer is in flight. An interrupt output combines the enabled status flags under a global enable. For read commands, the returned data is captured with the bits above the access width forced to zero.

Top module: `sbus_regfront`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `eng_start` and `eng_abort` are 0.
- R2: Writing CTRL (offset 0x00) with bit 7 set while idle gives a one-cycle `eng_start` pulse with `eng_mode`=0 in the next cycle. CTRL bit 7 reads 1 until `eng_done`, then 0. Setting bit 7 again while a transfer or mode sequence runs produces no `eng_start`.
- R3: Writing CTRL with bit 6 set pulses `eng_abort` for one cycle and clears CTRL bit 7 and MODE bit 31 without setting any status flag. An `eng_done` arriving while nothing runs changes no status.
- R4: Writing CTRL with bit 0 set makes CTRL bit 0 read 1 for one cycle. After that cycle every register, including status, returns to its reset value.
- R5: STAT (offset 0x0C) has bit 0 = over, bit 1 = error, bit 2 = load-busy, bits 11:8 = failing byte index and bit 16 = no-acknowledge. An `eng_done` without `eng_err` sets bit 0. An `eng_done` with `eng_err` sets bit 1 and captures `eng_err_byte` and `eng_nack`. Writing 1 to bit 0 or bit 2 clears that bit. Writing 1 to bit 1 clears bits 1, 11:8 and 16. Writing 0 leaves a bit unchanged.
- R6: A write to ADDR (0x10), DATA (0x14) or CMD (0x18) while CTRL bit 7 is set leaves that register unchanged and sets STAT bit 2.
- R7: `irq` = CTRL bit 1 AND (any of STAT bits 2:0 whose bit of the same position in IEN, offset 0x08, is 1).
- R8: CMD bit 4 = 1 selects a read and CMD bits 1:0 select the width (0: 8 bits, 1: 16 bits, 2 or 3: 32 bits). A successful read loads DATA with `eng_rdata`, with the bits above the width set to zero. A failed read and any write command leave DATA unchanged.
- R9: Writing MODE (0x1C) with bit 31 set while idle gives a one-cycle `eng_start` with `eng_mode`=1. MODE bit 31 reads 1 until `eng_done`, then 0, and the end sets STAT bit 0. MODE bits 23:16 drive `eng_mode_data` and bits 15:8 drive `eng_mode_reg`.
- R10: DEVADDR (0x20) bits 23:16 drive `eng_rt_addr` and bits 15:0 drive `eng_hw_addr`. CLKCFG (0x04) bits 7:0 drive `clk_div` and bits 10:8 drive `out_dly`. ADDR bits 7:0, DATA and CMD bits 7:0 drive `eng_reg_addr`, `eng_wdata` and `eng_cmd`.
- R11: Each register reads back its stored fields, with unused bits as 0. Any offset other than 0x00-0x20 (step 4) reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | One-cycle start to the serial engine |
| eng_mode | output | 1 | 1: the started job is the mode-init sequence |
| eng_abort | output | 1 | One-cycle abort to the serial engine |
| eng_cmd | output | 8 | Command byte |
| eng_reg_addr | output | 8 | Target register byte |
| eng_wdata | output | 32 | Write data |
| eng_rt_addr | output | 8 | Runtime device address |
| eng_hw_addr | output | 16 | Hardware device address |
| eng_mode_data | output | 8 | Mode-init data byte |
| eng_mode_reg | output | 8 | Mode-init register byte |
| clk_div | output | 8 | Bus clock divider |
| out_dly | output | 3 | Data-output delay |
| eng_done | input | 1 | Engine finished the current job |
| eng_err | input | 1 | With `eng_done`: job failed |
| eng_nack | input | 1 | With `eng_err`: target gave no acknowledge |
| eng_err_byte | input | 4 | With `eng_err`: index of the failing byte |
| eng_rdata | input | 32 | Read data from the engine |

## Verification
The hardest situations to reach are those that only exist while a job is outstanding. Examples are a configuration write rejected as load-busy, a second start request, and an abort that has to drop a running mode sequence. The bench acts as the serial engine itself. It holds `eng_done` low for as long as a scenario needs, makes its register writes inside that window, and only then completes the job with a chosen error code and read word. A stray completion after an abort and the one-cycle window of the self-clearing soft reset are each sampled on the exact cycle the registers make them visible.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    localparam int REG_W = 32;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_CLKCFG = 8'h04;
    localparam logic [7:0] OFS_IEN    = 8'h08;
    localparam logic [7:0] OFS_STAT   = 8'h0C;
    localparam logic [7:0] OFS_ADDR   = 8'h10;
    localparam logic [7:0] OFS_DATA   = 8'h14;
    localparam logic [7:0] OFS_CMD    = 8'h18;
    localparam logic [7:0] OFS_MODE   = 8'h1C;
    localparam logic [7:0] OFS_DEV    = 8'h20;

    // control bit positions
    localparam int CB_GO    = 7;
    localparam int CB_STOP  = 6;
    localparam int CB_GIE   = 1;
    localparam int CB_SRST  = 0;
    localparam int MB_GO    = 31;

    // command field positions
    localparam int CMD_RD_BIT = 4;

    typedef struct packed {
        logic run;
        logic mode_busy;
        logic gie;
        logic srst;
        logic start_p;
        logic mode_p;
        logic abort_p;
    } ctl_state_t;

    typedef struct packed {
        logic       over;
        logic       err;
        logic       ldb;
        logic       nack;
        logic [3:0] ebyte;
    } stat_state_t;

    function automatic logic [REG_W-1:0] width_mask(input logic [1:0] w);
        logic [REG_W-1:0] m;
        case (w)
            2'd0:    m = {{(REG_W-8){1'b0}},  8'hFF};
            2'd1:    m = {{(REG_W-16){1'b0}}, 16'hFFFF};
            default: m = {REG_W{1'b1}};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sbus_xfer_ctl.sv
module sbus_xfer_ctl
    import sbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic wr_mode,
    input  logic w_go,
    input  logic w_stop,
    input  logic w_gie,
    input  logic w_srst,
    input  logic w_mode_go,
    input  logic eng_done,
    output logic run,
    output logic mode_busy,
    output logic gie,
    output logic srst,
    output logic start_p,
    output logic mode_p,
    output logic abort_p,
    output logic xfer_end,
    output logic mode_end
);

    ctl_state_t st_d, st_q;
    logic idle;

    always_comb begin
        st_d         = st_q;
        st_d.start_p = 1'b0;
        st_d.abort_p = 1'b0;
        idle         = !st_q.run && !st_q.mode_busy && !st_q.srst;
        xfer_end     = st_q.run && eng_done;
        mode_end     = st_q.mode_busy && eng_done;

        if (xfer_end) st_d.run       = 1'b0;
        if (mode_end) st_d.mode_busy = 1'b0;

        if (wr_ctrl) begin
            st_d.gie = w_gie;
            if (w_srst) st_d.srst = 1'b1;
            if (w_stop) begin
                st_d.abort_p   = 1'b1;
                st_d.run       = 1'b0;
                st_d.mode_busy = 1'b0;
            end else if (w_go && idle && !w_srst) begin
                st_d.run     = 1'b1;
                st_d.start_p = 1'b1;
                st_d.mode_p  = 1'b0;
            end
        end

        if (wr_mode && w_mode_go && idle) begin
            st_d.mode_busy = 1'b1;
            st_d.start_p   = 1'b1;
            st_d.mode_p    = 1'b1;
        end

        if (st_q.srst) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run       = st_q.run;
    assign mode_busy = st_q.mode_busy;
    assign gie       = st_q.gie;
    assign srst      = st_q.srst;
    assign start_p   = st_q.start_p;
    assign mode_p    = st_q.mode_p;
    assign abort_p   = st_q.abort_p;

endmodule

// File: rtl/sbus_status.sv
module sbus_status
    import sbus_pkg::*;
#(
    parameter int FLAG_N = 3,
    parameter int EB_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              wr_stat,
    input  logic [FLAG_N-1:0] w_clr,
    input  logic              end_evt,
    input  logic              eng_err,
    input  logic              eng_nack,
    input  logic [EB_W-1:0]   eng_err_byte,
    input  logic              ldb_evt,
    input  logic [FLAG_N-1:0] ien,
    input  logic              gie,
    output logic [REG_W-1:0]  stat_word,
    output logic              irq
);

    stat_state_t        s_d, s_q;
    logic [FLAG_N-1:0]  flags;

    always_comb begin
        s_d = s_q;
        if (wr_stat) begin
            if (w_clr[0]) s_d.over = 1'b0;
            if (w_clr[1]) begin
                s_d.err   = 1'b0;
                s_d.nack  = 1'b0;
                s_d.ebyte = '0;
            end
            if (w_clr[2]) s_d.ldb = 1'b0;
        end
        if (end_evt) begin
            if (eng_err) begin
                s_d.err   = 1'b1;
                s_d.nack  = eng_nack;
                s_d.ebyte = eng_err_byte;
            end else begin
                s_d.over = 1'b1;
            end
        end
        if (ldb_evt)  s_d.ldb = 1'b1;
        if (soft_clr) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags = {s_q.ldb, s_q.err, s_q.over};
    assign irq   = gie && (|(flags & ien));

    always_comb begin
        stat_word       = '0;
        stat_word[0]    = s_q.over;
        stat_word[1]    = s_q.err;
        stat_word[2]    = s_q.ldb;
        stat_word[11:8] = s_q.ebyte;
        stat_word[16]   = s_q.nack;
    end

endmodule

// File: rtl/sbus_shadow_regs.sv
module sbus_shadow_regs
    import sbus_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int DLY_W  = 3,
    parameter int RT_W   = 8,
    parameter int HW_W   = 16,
    parameter int FLAG_N = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              xfer_busy,
    input  logic              any_busy,
    input  logic              wr_clk,
    input  logic              wr_ien,
    input  logic              wr_addr,
    input  logic              wr_data,
    input  logic              wr_cmd,
    input  logic              wr_dev,
    input  logic              wr_mode,
    input  logic [REG_W-1:0]  wdata,
    input  logic              xfer_end,
    input  logic              eng_err,
    input  logic [REG_W-1:0]  eng_rdata,
    output logic [DIV_W-1:0]  clk_div,
    output logic [DLY_W-1:0]  out_dly,
    output logic [FLAG_N-1:0] ien,
    output logic [7:0]        reg_addr_q,
    output logic [REG_W-1:0]  data_q,
    output logic [7:0]        cmd_q,
    output logic [RT_W-1:0]   rt_addr,
    output logic [HW_W-1:0]   hw_addr,
    output logic [7:0]        mode_data,
    output logic [7:0]        mode_reg,
    output logic              ldb_evt
);

    localparam int RT_LSB = HW_W;
    localparam int DLY_LSB = DIV_W;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [DLY_W-1:0]  dly;
        logic [FLAG_N-1:0] ien;
        logic [7:0]        addr;
        logic [REG_W-1:0]  data;
        logic [7:0]        cmd;
        logic [RT_W-1:0]   rt;
        logic [HW_W-1:0]   hw;
        logic [7:0]        mdata;
        logic [7:0]        mreg;
    } shd_t;

    shd_t r_d, r_q;
    logic rd_load;

    always_comb begin
        r_d     = r_q;
        ldb_evt = xfer_busy && (wr_addr || wr_data || wr_cmd);
        rd_load = xfer_end && !eng_err && r_q.cmd[CMD_RD_BIT];

        if (wr_clk) begin
            r_d.div = wdata[DIV_W-1:0];
            r_d.dly = wdata[DLY_LSB +: DLY_W];
        end
        if (wr_ien) r_d.ien = wdata[FLAG_N-1:0];
        if (wr_dev) begin
            r_d.hw = wdata[HW_W-1:0];
            r_d.rt = wdata[RT_LSB +: RT_W];
        end
        if (wr_mode && !any_busy) begin
            r_d.mdata = wdata[23:16];
            r_d.mreg  = wdata[15:8];
        end
        if (!xfer_busy) begin
            if (wr_addr) r_d.addr = wdata[7:0];
            if (wr_data) r_d.data = wdata;
            if (wr_cmd)  r_d.cmd  = wdata[7:0];
        end
        if (rd_load) r_d.data = eng_rdata & width_mask(r_q.cmd[1:0]);

        if (soft_clr) r_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign clk_div    = r_q.div;
    assign out_dly    = r_q.dly;
    assign ien        = r_q.ien;
    assign reg_addr_q = r_q.addr;
    assign data_q     = r_q.data;
    assign cmd_q      = r_q.cmd;
    assign rt_addr    = r_q.rt;
    assign hw_addr    = r_q.hw;
    assign mode_data  = r_q.mdata;
    assign mode_reg   = r_q.mreg;

endmodule

// File: rtl/sbus_regfront.sv
module sbus_regfront
    import sbus_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int DLY_W = 3,
    parameter int RT_W  = 8,
    parameter int HW_W  = 16,
    parameter int EB_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq,
    output logic             eng_start,
    output logic             eng_mode,
    output logic             eng_abort,
    output logic [7:0]       eng_cmd,
    output logic [7:0]       eng_reg_addr,
    output logic [31:0]      eng_wdata,
    output logic [RT_W-1:0]  eng_rt_addr,
    output logic [HW_W-1:0]  eng_hw_addr,
    output logic [7:0]       eng_mode_data,
    output logic [7:0]       eng_mode_reg,
    output logic [DIV_W-1:0] clk_div,
    output logic [DLY_W-1:0] out_dly,
    input  logic             eng_done,
    input  logic             eng_err,
    input  logic             eng_nack,
    input  logic [EB_W-1:0]  eng_err_byte,
    input  logic [31:0]      eng_rdata
);

    localparam int FLAG_N = 3;

    logic wr_ctrl, wr_clk, wr_ien, wr_stat, wr_addr, wr_data, wr_cmd, wr_mode, wr_dev;
    logic run, mode_busy, gie, srst, xfer_end, mode_end, ldb_evt;
    logic [FLAG_N-1:0] ien;
    logic [REG_W-1:0]  stat_word;

    assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
    assign wr_clk  = reg_wr && (reg_addr == OFS_CLKCFG);
    assign wr_ien  = reg_wr && (reg_addr == OFS_IEN);
    assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
    assign wr_addr = reg_wr && (reg_addr == OFS_ADDR);
    assign wr_data = reg_wr && (reg_addr == OFS_DATA);
    assign wr_cmd  = reg_wr && (reg_addr == OFS_CMD);
    assign wr_mode = reg_wr && (reg_addr == OFS_MODE);
    assign wr_dev  = reg_wr && (reg_addr == OFS_DEV);

    sbus_xfer_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wr_mode   (wr_mode),
        .w_go      (reg_wdata[CB_GO]),
        .w_stop    (reg_wdata[CB_STOP]),
        .w_gie     (reg_wdata[CB_GIE]),
        .w_srst    (reg_wdata[CB_SRST]),
        .w_mode_go (reg_wdata[MB_GO]),
        .eng_done  (eng_done),
        .run       (run),
        .mode_busy (mode_busy),
        .gie       (gie),
        .srst      (srst),
        .start_p   (eng_start),
        .mode_p    (eng_mode),
        .abort_p   (eng_abort),
        .xfer_end  (xfer_end),
        .mode_end  (mode_end)
    );

    sbus_status #(.FLAG_N(FLAG_N), .EB_W(EB_W)) u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_clr     (srst),
        .wr_stat      (wr_stat),
        .w_clr        (reg_wdata[FLAG_N-1:0]),
        .end_evt      (xfer_end || mode_end),
        .eng_err      (eng_err),
        .eng_nack     (eng_nack),
        .eng_err_byte (eng_err_byte),
        .ldb_evt      (ldb_evt),
        .ien          (ien),
        .gie          (gie),
        .stat_word    (stat_word),
        .irq          (irq)
    );

    sbus_shadow_regs #(
        .DIV_W(DIV_W), .DLY_W(DLY_W), .RT_W(RT_W), .HW_W(HW_W), .FLAG_N(FLAG_N)
    ) u_shd (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_clr   (srst),
        .xfer_busy  (run),
        .any_busy   (run || mode_busy),
        .wr_clk     (wr_clk),
        .wr_ien     (wr_ien),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_cmd     (wr_cmd),
        .wr_dev     (wr_dev),
        .wr_mode    (wr_mode),
        .wdata      (reg_wdata),
        .xfer_end   (xfer_end),
        .eng_err    (eng_err),
        .eng_rdata  (eng_rdata),
        .clk_div    (clk_div),
        .out_dly    (out_dly),
        .ien        (ien),
        .reg_addr_q (eng_reg_addr),
        .data_q     (eng_wdata),
        .cmd_q      (eng_cmd),
        .rt_addr    (eng_rt_addr),
        .hw_addr    (eng_hw_addr),
        .mode_data  (eng_mode_data),
        .mode_reg   (eng_mode_reg),
        .ldb_evt    (ldb_evt)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[CB_GO]   = run;
                reg_rdata[CB_GIE]  = gie;
                reg_rdata[CB_SRST] = srst;
            end
            OFS_CLKCFG: reg_rdata = (32'(out_dly) << DIV_W) | 32'(clk_div);
            OFS_IEN:    reg_rdata = 32'(ien);
            OFS_STAT:   reg_rdata = stat_word;
            OFS_ADDR:   reg_rdata = 32'(eng_reg_addr);
            OFS_DATA:   reg_rdata = eng_wdata;
            OFS_CMD:    reg_rdata = 32'(eng_cmd);
            OFS_MODE: begin
                reg_rdata[MB_GO]   = mode_busy;
                reg_rdata[23:16]   = eng_mode_data;
                reg_rdata[15:8]    = eng_mode_reg;
            end
            OFS_DEV:    reg_rdata = (32'(eng_rt_addr) << HW_W) | 32'(eng_hw_addr);
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sbus_regfront_chk.sv
module sbus_regfront_chk
    import sbus_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        run,
    input logic        mode_busy,
    input logic        gie,
    input logic        srst,
    input logic        irq,
    input logic        eng_start,
    input logic        eng_abort,
    input logic        eng_done,
    input logic        end_evt,
    input logic [7:0]  eng_reg_addr,
    input logic [31:0] stat_word
);

    logic wr_ctrl_c, wr_stat_c, wr_addr_c;
    assign wr_ctrl_c = reg_wr && (reg_addr == OFS_CTRL);
    assign wr_stat_c = reg_wr && (reg_addr == OFS_STAT);
    assign wr_addr_c = reg_wr && (reg_addr == OFS_ADDR);

    a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    a_r2_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        (run && eng_done && !srst) |=> !run);

    a_r3_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_c && reg_wdata[CB_STOP]) |=> (!run && !mode_busy && eng_abort));

    a_r4_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (stat_word == 32'd0 && !run && !mode_busy && !gie && !srst));

    a_r5_w1c_over: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat_c && reg_wdata[0] && !end_evt) |=> !stat_word[0]);

    a_r6_ldbusy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr_c && run && !srst) |=> ($stable(eng_reg_addr) && stat_word[2]));

    a_r7_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq);

    a_r9_mode_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_busy && eng_done && !srst) |=> !mode_busy);

endmodule

bind sbus_regfront sbus_regfront_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .run          (run),
    .mode_busy    (mode_busy),
    .gie          (gie),
    .srst         (srst),
    .irq          (irq),
    .eng_start    (eng_start),
    .eng_abort    (eng_abort),
    .eng_done     (eng_done),
    .end_evt      (xfer_end || mode_end),
    .eng_reg_addr (eng_reg_addr),
    .stat_word    (stat_word)
);

// File: tb/tb_sbus_regfront.sv
`timescale 1ns/1ps
module tb_sbus_regfront;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        irq, eng_start, eng_mode, eng_abort;
    logic [7:0]  eng_cmd, eng_reg_addr, eng_rt_addr, eng_mode_data, eng_mode_reg, clk_div;
    logic [31:0] eng_wdata;
    logic [15:0] eng_hw_addr;
    logic [2:0]  out_dly;
    logic        eng_done = 1'b0, eng_err = 1'b0, eng_nack = 1'b0;
    logic [3:0]  eng_err_byte = 4'h0;
    logic [31:0] eng_rdata = 32'h0;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    localparam logic [7:0] A_CTRL = 8'h00, A_CLK = 8'h04, A_IEN = 8'h08, A_STAT = 8'h0C,
                           A_ADDR = 8'h10, A_DATA = 8'h14, A_CMD = 8'h18, A_MODE = 8'h1C,
                           A_DEV = 8'h20;

    always #2.5 clk = ~clk;

    sbus_regfront dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .eng_start(eng_start), .eng_mode(eng_mode), .eng_abort(eng_abort),
        .eng_cmd(eng_cmd), .eng_reg_addr(eng_reg_addr), .eng_wdata(eng_wdata),
        .eng_rt_addr(eng_rt_addr), .eng_hw_addr(eng_hw_addr),
        .eng_mode_data(eng_mode_data), .eng_mode_reg(eng_mode_reg),
        .clk_div(clk_div), .out_dly(out_dly), .eng_done(eng_done),
        .eng_err(eng_err), .eng_nack(eng_nack), .eng_err_byte(eng_err_byte),
        .eng_rdata(eng_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 32'h0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic finish_job(input logic e, input logic nk, input logic [3:0] b,
                              input logic [31:0] rdv);
        @(negedge clk);
        eng_done = 1'b1; eng_err = e; eng_nack = nk; eng_err_byte = b; eng_rdata = rdv;
        @(negedge clk);
        eng_done = 1'b0; eng_err = 1'b0; eng_nack = 1'b0; eng_err_byte = 4'h0;
    endtask

    task automatic t_reset;
        rchk("R1 ctrl", A_CTRL, 0);  rchk("R1 clk", A_CLK, 0);
        rchk("R1 ien", A_IEN, 0);    rchk("R1 stat", A_STAT, 0);
        rchk("R1 addr", A_ADDR, 0);  rchk("R1 data", A_DATA, 0);
        rchk("R1 cmd", A_CMD, 0);    rchk("R1 mode", A_MODE, 0);
        rchk("R1 dev", A_DEV, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 start", 32'(eng_start), 0);
        chk("R1 abort", 32'(eng_abort), 0);
        rchk("R11 unmapped", 8'h3C, 0);
    endtask

    task automatic t_cfg;
        wr(A_CLK, 32'hFFFF_F5A7);
        chk("R10 clk_div", 32'(clk_div), 32'hA7);
        chk("R10 out_dly", 32'(out_dly), 32'h5);
        rchk("R11 clk rb", A_CLK, 32'h0000_05A7);
        wr(A_DEV, 32'hFF2D_03A3);
        chk("R10 rt", 32'(eng_rt_addr), 32'h2D);
        chk("R10 hw", 32'(eng_hw_addr), 32'h03A3);
        rchk("R11 dev rb", A_DEV, 32'h002D_03A3);
        wr(A_IEN, 32'hFFFF_FFFF);
        rchk("R11 ien rb", A_IEN, 32'h7);
        wr(A_IEN, 32'h0);
    endtask

    task automatic t_write_xfer;
        wr(A_ADDR, 32'h0000_0012);
        wr(A_DATA, 32'hCAFE_BABE);
        wr(A_CMD, 32'h0000_0002);
        chk("R10 reg addr", 32'(eng_reg_addr), 32'h12);
        chk("R10 wdata", eng_wdata, 32'hCAFE_BABE);
        chk("R10 cmd", 32'(eng_cmd), 32'h02);
        wr(A_CTRL, 32'h80);
        chk("R2 start", 32'(eng_start), 1);
        chk("R2 mode0", 32'(eng_mode), 0);
        rchk("R2 busy", A_CTRL, 32'h80);
        @(negedge clk);
        chk("R2 pulse", 32'(eng_start), 0);
        finish_job(0, 0, 0, 32'h1111_1111);
        rchk("R2 self clr", A_CTRL, 0);
        rchk("R5 over", A_STAT, 32'h1);
        rchk("R8 write keeps data", A_DATA, 32'hCAFE_BABE);
        wr(A_STAT, 32'h0);
        rchk("R5 zero no effect", A_STAT, 32'h1);
        wr(A_STAT, 32'h1);
        rchk("R5 w1c over", A_STAT, 0);
    endtask

    task automatic t_read_widths;
        logic [31:0] expv [3] = '{32'h0000_00F1, 32'h0000_96F1, 32'hA5C3_96F1};
        for (int w = 0; w < 3; w++) begin
            wr(A_DATA, 32'h0);
            wr(A_CMD, 32'h10 | w);
            wr(A_CTRL, 32'h80);
            finish_job(0, 0, 0, 32'hA5C3_96F1);
            rchk("R8 read mask", A_DATA, expv[w]);
            wr(A_STAT, 32'h7);
        end
    endtask

    task automatic t_error;
        wr(A_DATA, 32'h0000_5555);
        wr(A_CMD, 32'h12);
        wr(A_CTRL, 32'h80);
        finish_job(1, 1, 4'h3, 32'hFFFF_FFFF);
        rchk("R5 error fields", A_STAT, 32'h0001_0302);
        rchk("R8 failed read keeps", A_DATA, 32'h0000_5555);
        wr(A_STAT, 32'h1);
        rchk("R5 other bit stays", A_STAT, 32'h0001_0302);
        wr(A_STAT, 32'h2);
        rchk("R5 err clear", A_STAT, 0);
    endtask

    task automatic t_ldbusy;
        wr(A_ADDR, 32'h40);
        wr(A_CMD, 32'h02);
        wr(A_CTRL, 32'h80);
        wr(A_ADDR, 32'h55);
        rchk("R6 addr held", A_ADDR, 32'h40);
        rchk("R6 flag", A_STAT, 32'h4);
        wr(A_DATA, 32'h1234);
        rchk("R6 data held", A_DATA, 32'h5555);
        wr(A_CMD, 32'h13);
        rchk("R6 cmd held", A_CMD, 32'h02);
        wr(A_CTRL, 32'h80);
        chk("R2 restart ignored", 32'(eng_start), 0);
        finish_job(0, 0, 0, 0);
        rchk("R6 both flags", A_STAT, 32'h5);
        wr(A_ADDR, 32'h55);
        rchk("R6 idle write ok", A_ADDR, 32'h55);
        wr(A_STAT, 32'h4);
        rchk("R5 w1c ldb", A_STAT, 32'h1);
        wr(A_STAT, 32'h7);
    endtask

    task automatic t_irq;
        wr(A_CTRL, 32'h80);
        finish_job(0, 0, 0, 0);
        chk("R7 no en", 32'(irq), 0);
        wr(A_IEN, 32'h1);
        chk("R7 no gie", 32'(irq), 0);
        wr(A_CTRL, 32'h02);
        chk("R7 on", 32'(irq), 1);
        wr(A_IEN, 32'h2);
        chk("R7 other enable", 32'(irq), 0);
        wr(A_IEN, 32'h1);
        wr(A_STAT, 32'h1);
        chk("R7 cleared", 32'(irq), 0);
    endtask

    task automatic t_abort;
        wr(A_CTRL, 32'h82);
        wr(A_CTRL, 32'h42);
        chk("R3 abort pulse", 32'(eng_abort), 1);
        rchk("R3 ctrl", A_CTRL, 32'h02);
        rchk("R3 no status", A_STAT, 0);
        finish_job(0, 0, 0, 0);
        rchk("R3 stray done", A_STAT, 0);
        wr(A_MODE, 32'h8000_0000);
        wr(A_CTRL, 32'h40);
        rchk("R3 mode dropped", A_MODE, 0);
    endtask

    task automatic t_mode;
        wr(A_MODE, 32'h8071_3E00);
        chk("R9 start", 32'(eng_start), 1);
        chk("R9 mode", 32'(eng_mode), 1);
        chk("R9 data", 32'(eng_mode_data), 32'h71);
        chk("R9 reg", 32'(eng_mode_reg), 32'h3E);
        rchk("R9 busy", A_MODE, 32'h8071_3E00);
        rchk("R9 ctrl idle", A_CTRL, 0);
        finish_job(0, 0, 0, 0);
        rchk("R9 self clr", A_MODE, 32'h0071_3E00);
        rchk("R9 over", A_STAT, 32'h1);
    endtask

    task automatic t_srst;
        wr(A_IEN, 32'h7);
        wr(A_CTRL, 32'h01);
        rchk("R4 bit visible", A_CTRL, 32'h01);
        @(negedge clk);
        rchk("R4 ctrl", A_CTRL, 0);
        rchk("R4 stat", A_STAT, 0);
        rchk("R4 ien", A_IEN, 0);
        rchk("R4 clk", A_CLK, 0);
        rchk("R4 mode", A_MODE, 0);
        rchk("R4 addr", A_ADDR, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_write_xfer();
        t_read_widths();
        t_error();
        t_ldbusy();
        t_irq();
        t_abort();
        t_mode();
        t_srst();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule